// File: doc/BRIEF.md
# Receive CAS Monitor and Insert

This block sits in the receive signalling path of a multiframed TDM port that carries channel-associated signalling (CAS). Each time the channel scheduler presents a channel, the block gets that channel's 4-bit ABCD value read from reassembly memory. It also gets a flag that says whether that value came from an underrun, and the channel's configuration bits. From these it decides the nibble to drive on the odd TDM stream. A software-supplied nibble can replace the memory value.

The block keeps, per channel, the last CAS value it drove. When monitoring is enabled and the outgoing value differs from the stored one, it raises a one-clock change report carrying the channel number and the new value. Values that arrive with an underrun never refresh the stored copy and never raise a report. When CAS underrun reporting is enabled, such values raise an underrun event instead. A 4-bit framing code selects E1 or T1 and strict or fast CAS transport. Reserved codes make the channel inert.

All results appear on registered outputs one clock after the presenting cycle.

Top module: `rx_cas_monitor`

## Requirements
- R1: The framing code is valid only for 4'b0100, 4'b0101, 4'b0110 and 4'b0111. For a presented channel with a valid code, `fmt_t1` equals code bit 1 (1 = T1, 0 = E1) and `fmt_fast` equals code bit 0 (1 = fast CAS, 0 = strict).
- R2: For a valid code, `cas_val` is `in_man_val` when `in_man_en` is 1, and `in_mem_cas` otherwise.
- R3: `chg_stb` pulses when `in_mon_en` is 1, the code is valid, there is no underrun and the selected value differs from the stored last value of `in_chan`. While `chg_stb` is high, `chg_chan` and `chg_val` give the channel and the new value. Otherwise they are 0.
- R4: No change report is raised for a value presented with `in_underrun` = 1.
- R5: On a cycle with a valid code and no underrun, the channel's stored last value takes the selected value, whether or not monitoring is on. On an underrun cycle it keeps its old value.
- R6: `cas_oe` is 1 only for a presented channel with a valid code and `in_oe_en` = 1.
- R7: `ur_stb` pulses when a valid-code channel is presented with `in_underrun` = 1 and `in_cu_en` = 1.
- R8: With a reserved code, all outputs stay 0 (no drive, no report, no underrun event), and the stored value is not changed.
- R9: Reset clears all stored last values to 0 and holds every output at 0.
- R10: Outputs follow the presenting cycle by exactly one clock. On a clock with `in_vld` = 0, every output is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A channel is presented this cycle |
| in_chan | input | 5 | Channel number (clog2 of NCH) |
| in_mode | input | 4 | Framing code |
| in_man_en | input | 1 | Manual CAS insertion enable |
| in_man_val | input | 4 | Manual CAS value |
| in_mon_en | input | 1 | Change monitoring enable |
| in_oe_en | input | 1 | CAS output enable |
| in_cu_en | input | 1 | CAS underrun event enable |
| in_mem_cas | input | 4 | CAS value read from memory |
| in_underrun | input | 1 | Memory value is an underrun |
| cas_val | output | 4 | CAS nibble for the odd stream |
| cas_oe | output | 1 | Drive enable for `cas_val` |
| fmt_t1 | output | 1 | Framing is T1 |
| fmt_fast | output | 1 | Fast CAS transport |
| chg_stb | output | 1 | One-clock change report |
| chg_chan | output | 5 | Channel of the change report |
| chg_val | output | 4 | New CAS value of the change report |
| ur_stb | output | 1 | CAS underrun event |

## Verification
The bench first drives fixed patterns on a few channels. These patterns repeat the same value, change it with monitoring on and off, and use manual insertion with a memory value that differs, to show that the manual nibble is the one compared and stored. Underrun sequences present a new value with an underrun and then the old value cleanly. A report at that point would show that the store was wrongly refreshed. Reserved codes are then followed by the prior value, to show that no state was touched. A long random run across all channels, framing codes and enables then compares every output each clock against a behavioural per-channel model.

// File: rtl/rx_cas_pkg.sv
package rx_cas_pkg;
  typedef logic [3:0] cas_t;

  typedef struct packed {
    logic [3:0] mode;
    logic       man_en;
    cas_t       man_val;
    logic       mon_en;
    logic       oe_en;
    logic       cu_en;
  } chan_cfg_t;

  // framing code space: only 01xx is defined
  function automatic logic mode_valid(input logic [3:0] mode);
    return mode[3:2] == 2'b01;
  endfunction

  function automatic cas_t pick_cas(input logic man_en, input cas_t man, input cas_t mem);
    return man_en ? man : mem;
  endfunction
endpackage

// File: rtl/rx_cas_decide.sv
module rx_cas_decide
  import rx_cas_pkg::*;
(
  input  logic      vld,
  input  chan_cfg_t cfg,
  input  cas_t      mem_cas,
  input  logic      underrun,
  input  cas_t      last_cas,
  output logic      active,
  output cas_t      sel_cas,
  output logic      commit,
  output logic      report,
  output logic      ur_evt,
  output logic      drive
);
  always_comb begin
    active  = vld && mode_valid(cfg.mode);
    sel_cas = pick_cas(cfg.man_en, cfg.man_val, mem_cas);
    commit  = active && !underrun;
    report  = commit && cfg.mon_en && (sel_cas != last_cas);
    ur_evt  = active && underrun && cfg.cu_en;
    drive   = active && cfg.oe_en;
  end
endmodule

// File: rtl/rx_cas_last_store.sv
module rx_cas_last_store
  import rx_cas_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rd_chan,
  output cas_t          rd_val,
  input  logic          wr_en,
  input  cas_t          wr_val
);
  cas_t store [NCH];

  assign rd_val = store[rd_chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) store[i] <= '0;
    end else if (wr_en) begin
      store[rd_chan] <= wr_val;
    end
  end
endmodule

// File: rtl/rx_cas_monitor.sv
module rx_cas_monitor
  import rx_cas_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [CW-1:0] in_chan,
  input  logic [3:0]    in_mode,
  input  logic          in_man_en,
  input  logic [3:0]    in_man_val,
  input  logic          in_mon_en,
  input  logic          in_oe_en,
  input  logic          in_cu_en,
  input  logic [3:0]    in_mem_cas,
  input  logic          in_underrun,
  output logic [3:0]    cas_val,
  output logic          cas_oe,
  output logic          fmt_t1,
  output logic          fmt_fast,
  output logic          chg_stb,
  output logic [CW-1:0] chg_chan,
  output logic [3:0]    chg_val,
  output logic          ur_stb
);
  chan_cfg_t cfg;
  cas_t      last_w, sel_w;
  logic      active_w, commit_w, report_w, ur_evt_w, drive_w;

  assign cfg = '{mode: in_mode, man_en: in_man_en, man_val: in_man_val,
                 mon_en: in_mon_en, oe_en: in_oe_en, cu_en: in_cu_en};

  rx_cas_decide u_decide (
    .vld(in_vld), .cfg(cfg), .mem_cas(in_mem_cas), .underrun(in_underrun),
    .last_cas(last_w), .active(active_w), .sel_cas(sel_w), .commit(commit_w),
    .report(report_w), .ur_evt(ur_evt_w), .drive(drive_w)
  );

  rx_cas_last_store #(.NCH(NCH)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_chan(in_chan), .rd_val(last_w),
    .wr_en(commit_w), .wr_val(sel_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_val  <= '0;
      cas_oe   <= 1'b0;
      fmt_t1   <= 1'b0;
      fmt_fast <= 1'b0;
      chg_stb  <= 1'b0;
      chg_chan <= '0;
      chg_val  <= '0;
      ur_stb   <= 1'b0;
    end else begin
      cas_val  <= active_w ? sel_w : '0;
      cas_oe   <= drive_w;
      fmt_t1   <= active_w && in_mode[1];
      fmt_fast <= active_w && in_mode[0];
      chg_stb  <= report_w;
      chg_chan <= report_w ? in_chan : '0;
      chg_val  <= report_w ? sel_w : '0;
      ur_stb   <= ur_evt_w;
    end
  end
endmodule

// File: rtl/rx_cas_monitor_chk.sv
module rx_cas_monitor_chk #(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [3:0]    in_mode,
  input logic          in_man_en,
  input logic [3:0]    in_man_val,
  input logic          in_underrun,
  input logic          in_cu_en,
  input logic          commit_w,
  input logic [3:0]    cas_val,
  input logic          cas_oe,
  input logic          chg_stb,
  input logic [CW-1:0] chg_chan,
  input logic [3:0]    chg_val,
  input logic          ur_stb
);
  // R4
  no_report_on_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> $past(in_vld && !in_underrun));

  // R8
  reserved_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode[3:2] != 2'b01) |=> (!cas_oe && !chg_stb && !ur_stb && cas_val == 4'd0));

  // R8
  reserved_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode[3:2] != 2'b01) |-> !commit_w);

  // R2
  manual_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_man_en && in_mode[3:2] == 2'b01) |=> cas_val == $past(in_man_val));

  // R7
  ur_event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ur_stb |-> $past(in_vld && in_underrun && in_cu_en));

  // R3
  report_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> chg_val == cas_val);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!cas_oe && !chg_stb && !ur_stb && chg_chan == '0));
endmodule

bind rx_cas_monitor rx_cas_monitor_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
  .in_man_en(in_man_en), .in_man_val(in_man_val), .in_underrun(in_underrun),
  .in_cu_en(in_cu_en), .commit_w(commit_w), .cas_val(cas_val), .cas_oe(cas_oe),
  .chg_stb(chg_stb), .chg_chan(chg_chan), .chg_val(chg_val), .ur_stb(ur_stb)
);

// File: tb/tb_rx_cas_monitor.sv
module tb_rx_cas_monitor;
  localparam int NCH = 32;
  localparam int CW  = $clog2(NCH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 0, in_man_en = 0, in_mon_en = 0, in_oe_en = 0, in_cu_en = 0, in_underrun = 0;
  logic [CW-1:0] in_chan = '0;
  logic [3:0]    in_mode = '0, in_man_val = '0, in_mem_cas = '0;
  logic [3:0]    cas_val, chg_val;
  logic          cas_oe, fmt_t1, fmt_fast, chg_stb, ur_stb;
  logic [CW-1:0] chg_chan;

  int checks = 0, errors = 0;
  int last_ref [NCH];

  always #2 clk = ~clk;

  rx_cas_monitor #(.NCH(NCH)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one presenting cycle, then compare the registered result one clock later
  task automatic step(input int ch, input int mode, input bit man, input int manv, input bit mon,
                      input bit oe, input bit cu, input int mem, input bit ur, input bit vld);
    bit ok, e_oe, e_chg, e_ur, e_t1, e_fast;
    int sel, e_val;
    in_vld = vld; in_chan = CW'(ch); in_mode = 4'(mode); in_man_en = man; in_man_val = 4'(manv);
    in_mon_en = mon; in_oe_en = oe; in_cu_en = cu; in_mem_cas = 4'(mem); in_underrun = ur;
    ok     = vld && (mode >= 4 && mode <= 7);
    sel    = man ? manv : mem;
    e_val  = ok ? sel : 0;
    e_oe   = ok && oe;
    e_t1   = ok && ((mode / 2) % 2 == 1);
    e_fast = ok && (mode % 2 == 1);
    e_chg  = ok && mon && !ur && (sel != last_ref[ch]);
    e_ur   = ok && ur && cu;
    if (ok && !ur) last_ref[ch] = sel;
    @(negedge clk);
    check(cas_val == 4'(e_val), "R2 cas_val", cas_val, e_val);
    check(cas_oe == e_oe, "R6 cas_oe", cas_oe, e_oe);
    check(fmt_t1 == e_t1 && fmt_fast == e_fast, "R1 fmt", {fmt_t1, fmt_fast}, {e_t1, e_fast});
    check(chg_stb == e_chg, ur ? "R4 chg_stb" : "R3 chg_stb", chg_stb, e_chg);
    check(chg_chan == (e_chg ? CW'(ch) : '0) && chg_val == (e_chg ? 4'(sel) : 4'd0),
          "R3 chg fields", {chg_chan, chg_val}, e_chg ? ch * 16 + sel : 0);
    check(ur_stb == e_ur, "R7 ur_stb", ur_stb, e_ur);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) last_ref[i] = 0;
    repeat (3) @(negedge clk);
    // R9 outputs held at zero during reset
    check({cas_val, cas_oe, fmt_t1, fmt_fast, chg_stb, chg_val, ur_stb} == '0, "R9 reset", cas_val, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 store starts at 0: same value 0 gives no report
    step(3, 4, 0, 0, 1, 1, 0, 0, 0, 1);
    // R3 change on E1 strict, then repeat without change
    step(3, 4, 0, 0, 1, 1, 0, 9, 0, 1);
    step(3, 4, 0, 0, 1, 1, 0, 9, 0, 1);
    // R10 idle gap
    step(3, 4, 0, 0, 1, 1, 0, 5, 0, 0);
    // R5 monitor off still updates store; no report when later equal
    step(7, 6, 0, 0, 0, 0, 0, 12, 0, 1);
    step(7, 7, 0, 0, 1, 1, 0, 12, 0, 1);
    // R2 manual value used and compared, memory ignored
    step(7, 5, 1, 3, 1, 1, 0, 12, 0, 1);
    step(7, 5, 1, 3, 1, 1, 0, 1, 0, 1);
    // R4 R5 underrun: new value not reported, store keeps 3
    step(7, 5, 0, 0, 1, 1, 1, 8, 1, 1);
    step(7, 5, 0, 0, 1, 1, 0, 3, 0, 1);
    // R7 underrun with event disabled
    step(7, 5, 0, 0, 1, 1, 0, 8, 1, 1);
    // R8 reserved codes: nothing driven, store untouched
    step(9, 0, 0, 0, 1, 1, 1, 6, 0, 1);
    step(9, 8, 0, 0, 1, 1, 1, 6, 1, 1);
    step(9, 3, 1, 6, 1, 1, 1, 6, 0, 1);
    step(9, 4, 0, 0, 1, 1, 0, 0, 0, 1);
    // random run across all channels and codes
    for (int n = 0; n < 2000; n++) begin
      step($urandom_range(NCH - 1), $urandom_range(9), 1'($urandom), $urandom_range(15),
           1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(3),
           ($urandom_range(3) == 0), ($urandom_range(7) != 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule